// File: doc/BRIEF.md
# Carry-Save Multi-Operand Compressor (Linear Chain)

This block reduces `NOP` words of `N` bits each to a redundant pair: a sum word and a carry word whose ordinary sum equals the total of all inputs. It is built from `NOP-2` rows of 3:2 carry-save adders placed one after another. The carry word of each row goes to the carry input of the next row. The sum word of each row is fed back later as an ordinary operand. The carry path therefore runs unbroken from the first operand to the final carry word. This suits devices whose fast carry routing links neighbouring adders.

Each row has two regular inputs. These first take the remaining input operands in index order. They then take the partial sum words, oldest first. The callers sign- or zero-extend the operands beforehand, so the result stays `N` bits wide and any carry beyond the top bit is dropped. The block is purely combinational. A downstream carry-propagate adder turns the pair into a binary number.

Top module: `cs_compressor_top`

## Requirements
- R1: For any operands, `(sum_o + carry_o) mod 2^N` equals the sum of all `NOP` operands mod 2^N.
- R2: Bit 0 of `carry_o` is always 0. The carry word is already shifted left by one position.
- R3: With `NOP = 3`, operand 0 sits on the only row's carry input. `sum_o` is then the bitwise XOR of the three operands, and `carry_o` is their bitwise majority shifted left by one, with the top carry dropped.
- R4: When all operands are zero, both outputs are zero.
- R5: Carries past bit `N-1` are discarded. With every operand all ones, `sum_o + carry_o` wraps to `2^N - NOP`.
- R6: When exactly one operand is non-zero, at any position 0..NOP-1, `sum_o` equals that operand and `carry_o` is zero.
- R7: The outputs depend only on the present operands and follow them within the same cycle, with no clock or stored state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ops_i | input | NOP*N | Packed operands. Operand k occupies bits [k*N +: N]. |
| sum_o | output | N | Sum word of the carry-save result |
| carry_o | output | N | Carry word of the carry-save result, already weighted (bit 0 is zero) |

## Verification
The bench compares three widths of chain: `NOP` of 3, 9 and 10. The even count leaves a different mix of operands and partial sums in the last rows. A wrong re-injection order would feed a row a sum that has not yet been formed, or would drop one. The result would then miss the true total.

Operands of all ones test the wraparound. A design that kept the top carry, or forgot the one-bit shift, gives a pair that sums to the wrong value. It also shows up as a non-zero bit 0 in the carry word.

A lone non-zero operand is placed at every position in turn. This exposes any operand slot that is not wired to the chain.

The three-input case is checked bit by bit against XOR and majority. This catches a swapped sum or carry output.

// File: rtl/cs_tree_pkg.sv
package cs_tree_pkg;

    // Number of 3:2 rows needed to reduce nop operands to two words.
    function automatic int row_count(input int nop);
        return nop - 2;
    endfunction

    // The regular inputs of the rows read a single stream of slots.
    // Slots 1..nop-1 are the input operands. Slots nop and above are the
    // partial sum words in the order they were produced.
    function automatic bit slot_is_operand(input int nop, input int slot);
        return slot < nop;
    endfunction

    function automatic int slot_index(input int nop, input int slot);
        return (slot < nop) ? slot : slot - nop;
    endfunction

    // Slot read by regular input port p (0 or 1) of row r.
    function automatic int row_slot(input int r, input int p);
        return 2 * r + 1 + p;
    endfunction

endpackage

// File: rtl/fa_cell.sv
module fa_cell (
    input  logic a_i,
    input  logic b_i,
    input  logic c_i,
    output logic s_o,
    output logic co_o
);
    logic half;

    assign half = a_i ^ b_i;
    assign s_o  = half ^ c_i;
    assign co_o = (a_i & b_i) | (half & c_i);
endmodule

// File: rtl/csa_row.sv
module csa_row #(
    parameter int N = 16
) (
    input  logic [N-1:0] in_a,
    input  logic [N-1:0] in_b,
    input  logic [N-1:0] in_c,
    output logic [N-1:0] sum_o,
    output logic [N-1:0] cy_o
);
    // The carry word leaves the row already weighted by two.
    // The carry out of the top bit has no place in N bits and is not built.
    assign cy_o[0] = 1'b0;

    for (genvar b = 0; b < N; b++) begin : g_bit
        if (b < N - 1) begin : g_full
            fa_cell u_fa (
                .a_i (in_a[b]),
                .b_i (in_b[b]),
                .c_i (in_c[b]),
                .s_o (sum_o[b]),
                .co_o(cy_o[b+1])
            );
        end else begin : g_top
            assign sum_o[b] = in_a[b] ^ in_b[b] ^ in_c[b];
        end
    end
endmodule

// File: rtl/cs_compressor_top.sv
module cs_compressor_top #(
    parameter int NOP = 9,
    parameter int N   = 16
) (
    input  logic [NOP*N-1:0] ops_i,
    output logic [N-1:0]     sum_o,
    output logic [N-1:0]     carry_o
);
    localparam int NROW = cs_tree_pkg::row_count(NOP);

    logic [N-1:0] opnd [NOP];

    for (genvar k = 0; k < NOP; k++) begin : g_unpack
        assign opnd[k] = ops_i[k*N +: N];
    end

    for (genvar r = 0; r < NROW; r++) begin : g_row
        localparam int  SLOT_A = cs_tree_pkg::row_slot(r, 0);
        localparam int  SLOT_B = cs_tree_pkg::row_slot(r, 1);
        localparam bit  A_OP   = cs_tree_pkg::slot_is_operand(NOP, SLOT_A);
        localparam bit  B_OP   = cs_tree_pkg::slot_is_operand(NOP, SLOT_B);
        localparam int  A_IDX  = cs_tree_pkg::slot_index(NOP, SLOT_A);
        localparam int  B_IDX  = cs_tree_pkg::slot_index(NOP, SLOT_B);

        logic [N-1:0] op_a;
        logic [N-1:0] op_b;
        logic [N-1:0] op_c;
        logic [N-1:0] row_sum;
        logic [N-1:0] row_cy;

        // Carry input: operand 0 on the first row, else the previous carry word.
        if (r == 0) begin : g_head
            assign op_c = opnd[0];
        end else begin : g_link
            assign op_c = g_row[r-1].row_cy;
        end

        if (A_OP) begin : g_a_in
            assign op_a = opnd[A_IDX];
        end else begin : g_a_ps
            assign op_a = g_row[A_IDX].row_sum;
        end

        if (B_OP) begin : g_b_in
            assign op_b = opnd[B_IDX];
        end else begin : g_b_ps
            assign op_b = g_row[B_IDX].row_sum;
        end

        csa_row #(.N(N)) u_row (
            .in_a (op_a),
            .in_b (op_b),
            .in_c (op_c),
            .sum_o(row_sum),
            .cy_o (row_cy)
        );
    end

    assign sum_o   = g_row[NROW-1].row_sum;
    assign carry_o = g_row[NROW-1].row_cy;
endmodule

// File: rtl/cs_compressor_chk.sv
module cs_compressor_chk #(
    parameter int NOP = 9,
    parameter int N   = 16
) (
    input logic [NOP*N-1:0] ops_i,
    input logic [N-1:0]     sum_o,
    input logic [N-1:0]     carry_o
);
    logic [N-1:0] total;
    logic [N-1:0] lone;
    int           nonzero;

    always_comb begin
        total   = '0;
        lone    = '0;
        nonzero = 0;
        for (int k = 0; k < NOP; k++) begin
            total = total + ops_i[k*N +: N];
            if (ops_i[k*N +: N] != '0) begin
                nonzero = nonzero + 1;
                lone    = ops_i[k*N +: N];
            end
        end
        a_r1_total_congruent: assert (N'(sum_o + carry_o) == total);
        a_r2_carry_lsb_zero: assert (carry_o[0] == 1'b0);
        a_r4_zero_in_zero_out: assert (nonzero != 0 || (sum_o == '0 && carry_o == '0));
        a_r6_lone_operand_passes: assert (nonzero != 1 || (sum_o == lone && carry_o == '0));
    end

    if (NOP == 3) begin : g_three
        logic [N-1:0] x0, x1, x2, maj;
        assign x0  = ops_i[0 +: N];
        assign x1  = ops_i[N +: N];
        assign x2  = ops_i[2*N +: N];
        assign maj = (x0 & x1) | (x0 & x2) | (x1 & x2);
        always_comb begin
            a_r3_three_way_bitwise: assert (sum_o == (x0 ^ x1 ^ x2) && carry_o == N'({maj, 1'b0}));
        end
    end
endmodule

bind cs_compressor_top cs_compressor_chk #(.NOP(NOP), .N(N)) u_chk (.*);

// File: tb/cs_compressor_top_bench.sv
module cs_compressor_top_bench;

    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic [23:0]  ops3  = '0;
    logic [143:0] ops9  = '0;
    logic [159:0] ops10 = '0;
    logic [7:0]   s3, c3;
    logic [15:0]  s9, c9, s10, c10;

    int n_chk = 0;
    int n_bad = 0;

    cs_compressor_top #(.NOP(3), .N(8)) u_cs_compressor_top (
        .ops_i(ops3), .sum_o(s3), .carry_o(c3));
    cs_compressor_top #(.NOP(9), .N(16)) u_cs_compressor_top_n9 (
        .ops_i(ops9), .sum_o(s9), .carry_o(c9));
    cs_compressor_top #(.NOP(10), .N(16)) u_cs_compressor_top_n10 (
        .ops_i(ops10), .sum_o(s10), .carry_o(c10));

    task automatic note(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Behavioural reference: plain integer accumulation of every operand.
    function automatic logic [63:0] ref_total(input logic [159:0] flat,
                                              input int nop, input int n);
        longint acc = 0;
        for (int k = 0; k < nop; k++)
            for (int b = 0; b < n; b++)
                if (flat[k*n + b]) acc += (longint'(1) << b);
        return acc & ((64'd1 << n) - 1);
    endfunction

    task automatic cmp_one(input string req, input string who, input int nop, input int n,
                           input logic [159:0] flat, input logic [15:0] s, input logic [15:0] c);
        logic [63:0] mask = (64'd1 << n) - 1;
        logic [63:0] exp  = ref_total(flat, nop, n);
        logic [63:0] act  = (64'(s) + 64'(c)) & mask;
        note(act == exp, req, {who, " sum+carry"}, act, exp);
        note(c[0] == 1'b0, "R2", {who, " carry bit0"}, 64'(c[0]), 64'd0);
    endtask

    task automatic cmp_all(input string req);
        cmp_one(req, "nop3",  3,  8,  {136'b0, ops3}, {8'b0, s3}, {8'b0, c3});
        cmp_one(req, "nop9",  9,  16, {16'b0, ops9},  s9,  c9);
        cmp_one(req, "nop10", 10, 16, ops10,          s10, c10);
    endtask

    task automatic step_begin();
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(8 * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] a, b, c, maj;
        logic [15:0] v;

        // R4: reset-like state, all operands zero
        step_begin();
        ops3 = '0; ops9 = '0; ops10 = '0;
        #2;
        note(s3 == 0 && c3 == 0, "R4", "nop3 zero", {s3, c3}, 0);
        note(s9 == 0 && c9 == 0, "R4", "nop9 zero", {s9, c9}, 0);
        note(s10 == 0 && c10 == 0, "R4", "nop10 zero", {s10, c10}, 0);
        cmp_all("R4");

        // R5: all ones wraps to 2^N - NOP
        step_begin();
        ops3 = '1; ops9 = '1; ops10 = '1;
        #2;
        note(8'(s3 + c3) == 8'd253, "R5", "nop3 all ones", 8'(s3 + c3), 253);
        note(16'(s9 + c9) == 16'd65527, "R5", "nop9 all ones", 16'(s9 + c9), 65527);
        note(16'(s10 + c10) == 16'd65526, "R5", "nop10 all ones", 16'(s10 + c10), 65526);
        cmp_all("R5");

        // R6: lone non-zero operand at every position
        for (int k = 0; k < 10; k++) begin
            step_begin();
            ops3 = '0; ops9 = '0; ops10 = '0;
            v = 16'($urandom_range(1, 65535));
            if (k < 3) ops3[k*8 +: 8] = (v[7:0] == 0) ? 8'h5a : v[7:0];
            if (k < 9) ops9[k*16 +: 16] = v;
            ops10[k*16 +: 16] = v;
            #2;
            if (k < 3) note(s3 == ops3[k*8 +: 8] && c3 == 0, "R6", "nop3 lone",
                            {s3, c3}, {ops3[k*8 +: 8], 8'h00});
            if (k < 9) note(s9 == v && c9 == 0, "R6", "nop9 lone", {s9, c9}, {v, 16'h0});
            note(s10 == v && c10 == 0, "R6", "nop10 lone", {s10, c10}, {v, 16'h0});
        end

        // R3: three-operand case, bitwise XOR and shifted majority
        for (int t = 0; t < 40; t++) begin
            step_begin();
            a = 8'($urandom); b = 8'($urandom); c = 8'($urandom);
            if (t == 0) begin a = 8'hff; b = 8'hff; c = 8'hff; end
            ops3 = {c, b, a};
            maj = (a & b) | (a & c) | (b & c);
            #2;
            note(s3 == (a ^ b ^ c), "R3", "nop3 sum xor", s3, a ^ b ^ c);
            note(c3 == {maj[6:0], 1'b0}, "R3", "nop3 carry maj", c3, {maj[6:0], 1'b0});
        end

        // R1/R7: random and near-full operands, compared every clock in the same cycle
        for (int t = 0; t < 400; t++) begin
            step_begin();
            for (int k = 0; k < 10; k++) begin
                v = (t % 4 == 0) ? 16'hffff - 16'($urandom_range(0, 3)) : 16'($urandom);
                if (k < 3) ops3[k*8 +: 8] = v[7:0];
                if (k < 9) ops9[k*16 +: 16] = v ^ 16'(k);
                ops10[k*16 +: 16] = v + 16'(t);
            end
            #2;
            cmp_all("R1,R7");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end
endmodule